// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

After reset this block drives an SDRAM command bus through the DDR2 power-up procedure. It holds the bus idle for a programmable settling time, then issues the fixed series of precharge, mode-register, extended-mode-register and refresh commands. Each command is followed by a parameterized gap that covers the mode-register set time, the precharge time or the refresh cycle time, as the command requires. Every cycle that carries no command drives NOP.

The extended mode registers are chosen by the bank address. A system-side address, `sys_addr`, is also presented. Its bank value sits at a bit position that the block computes from the configured column-count code, row-count code, address mapping (sequential or bank-interleaved) and data-bus width. When the last command has completed, the block raises `init_done`, loads the configured refresh interval into `refi_q` for the refresh timer, and leaves the bus at NOP so that the normal controller can take over. The configuration inputs must stay stable from reset until `init_done` is high.

Top module: `ddr2_pwrup_seq`

## Requirements
- R1: While `rst_n` is low, the command is NOP ({cs_n,ras_n,cas_n,we_n} = 0111), `ba`, `addr` and `sys_addr` are zero, and `init_done` and `refi_q` are zero.
- R2: No command other than NOP appears in cycles 1 to W-1 after reset release, where W = CLK_MHZ*WAIT_US. The first command appears in cycle W.
- R3: The commands come in this order: precharge-all, EMRS2, EMRS3, EMRS1 (DLL enable), MRS with DLL reset, precharge-all, refresh, refresh, MRS without DLL reset, EMRS1 with OCD calibration-default, EMRS1 with OCD exit. The encodings are precharge 0010, refresh 0001 and mode-register set 0000.
- R4: The next command follows a command after exactly T_RP cycles for a precharge, T_RFC cycles for a refresh and T_MRD cycles for any mode-register set.
- R5: A precharge-all drives `ba` = 0 and an `addr` with only bit 10 set.
- R6: Both MRS commands drive `ba` = 0. The first drives `addr` = MR_BASE with bit 8 (DLL reset) set. The second drives MR_BASE with bit 8 clear.
- R7: EMRS2 and EMRS3 drive `ba` = 2 and 3 with `addr` = 0. The three EMRS1 commands drive `ba` = 1. Their `addr` is EMR1_BASE, then EMR1_BASE with bits 9:7 = 111, then EMR1_BASE with bits 9:7 = 000.
- R8: `sys_addr` equals `ba` shifted left by S, where S = cfg_col + 9, plus cfg_row + 11 when `cfg_seq_map` = 1, plus 2 when `cfg_wide` = 1 or 1 otherwise. On every other cycle `sys_addr` is zero.
- R9: `init_done` rises exactly T_MRD cycles after the final EMRS1, in the same cycle that `refi_q` takes `cfg_refi`. It then stays high until reset.
- R10: Every cycle that issues no command drives NOP, including every cycle after `init_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_col | input | COL_W | Column-count code (0 means 9 column bits) |
| cfg_row | input | ROW_W | Row-count code (0 means 11 row bits) |
| cfg_seq_map | input | 1 | 1 = sequential bank mapping, 0 = bank-interleaved |
| cfg_wide | input | 1 | 1 = wide data bus, 0 = narrow |
| cfg_refi | input | REFI_W | Refresh interval to hand to the refresh timer |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Row/mode address bus |
| sys_addr | output | SYS_W | System address carrying the bank at the computed bit position |
| init_done | output | 1 | Sequence complete |
| refi_q | output | REFI_W | Loaded refresh interval, valid once `init_done` is high |

## Verification
On every cycle, the embedded assertions check these properties:
- the bus stays quiet during the settling wait;
- each command is followed by at least one NOP;
- a non-zero bank is only ever paired with a mode-register set;
- `sys_addr` is zero whenever the bank is zero;
- the computed shift stays within its legal range;
- `init_done` never falls, and the bus stays at NOP once it is high.

The exact order of the commands, their cycle positions, their address and bank values, and the bit position that depends on geometry can only be shown by the bench. It runs the whole sequence under both mapping modes, both bus widths and several column and row codes, and compares each cycle against an independent timeline.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } ddr_cmd_e;

    typedef enum logic [1:0] {
        PH_WAIT = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } init_phase_e;

    typedef enum logic [3:0] {
        K_PREA,
        K_EMR2,
        K_EMR3,
        K_EMR1_DLL,
        K_MR_DLLRST,
        K_REF,
        K_MR_RUN,
        K_EMR1_OCDCAL,
        K_EMR1_OCDEXIT
    } step_kind_e;

    localparam int NUM_STEPS = 11;
    localparam int STEP_W    = $clog2(NUM_STEPS);

    // Order of the power-up commands; index 0 is issued first.
    function automatic step_kind_e step_kind(input logic [STEP_W-1:0] idx);
        case (idx)
            4'd0:    return K_PREA;
            4'd1:    return K_EMR2;
            4'd2:    return K_EMR3;
            4'd3:    return K_EMR1_DLL;
            4'd4:    return K_MR_DLLRST;
            4'd5:    return K_PREA;
            4'd6:    return K_REF;
            4'd7:    return K_REF;
            4'd8:    return K_MR_RUN;
            4'd9:    return K_EMR1_OCDCAL;
            default: return K_EMR1_OCDEXIT;
        endcase
    endfunction

endpackage

// File: rtl/ddr2_bank_shift.sv
module ddr2_bank_shift #(
    parameter int COL_W    = 2,
    parameter int ROW_W    = 2,
    parameter int SHIFT_W  = 5,
    parameter int COL_BASE = 9,
    parameter int ROW_BASE = 11
) (
    input  logic [COL_W-1:0]   col_i,
    input  logic [ROW_W-1:0]   row_i,
    input  logic               seq_i,
    input  logic               wide_i,
    output logic [SHIFT_W-1:0] shift_o
);

    logic [SHIFT_W-1:0] sh;

    always_comb begin
        sh = SHIFT_W'(COL_BASE) + SHIFT_W'(col_i);
        if (seq_i) begin
            sh = sh + SHIFT_W'(ROW_BASE) + SHIFT_W'(row_i);
        end
        sh = sh + (wide_i ? SHIFT_W'(2) : SHIFT_W'(1));
    end

    assign shift_o = sh;

endmodule

// File: rtl/ddr2_init_timer.sv
module ddr2_init_timer #(
    parameter int TW      = 16,
    parameter int RST_VAL = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] load_val_i,
    output logic          expired_o
);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= TW'(RST_VAL);
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

    // R4
    no_reload_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> expired_o);

endmodule

// File: rtl/ddr2_pwrup_seq.sv
module ddr2_pwrup_seq
    import ddr2_init_pkg::*;
#(
    parameter int CLK_MHZ     = 125,
    parameter int WAIT_US     = 200,
    parameter int T_MRD       = 2,
    parameter int T_RP        = 3,
    parameter int T_RFC       = 8,
    parameter int ADDR_W      = 14,
    parameter int BA_W        = 3,
    parameter int COL_W       = 2,
    parameter int ROW_W       = 2,
    parameter int SYS_W       = 32,
    parameter int REFI_W      = 12,
    parameter int AP_BIT      = 10,
    parameter int DLL_RST_BIT = 8,
    parameter int OCD_LSB     = 7,
    parameter logic [ADDR_W-1:0] MR_BASE   = 'h0242,
    parameter logic [ADDR_W-1:0] EMR1_BASE = 'h0004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COL_W-1:0]  cfg_col,
    input  logic [ROW_W-1:0]  cfg_row,
    input  logic              cfg_seq_map,
    input  logic              cfg_wide,
    input  logic [REFI_W-1:0] cfg_refi,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic [SYS_W-1:0]  sys_addr,
    output logic              init_done,
    output logic [REFI_W-1:0] refi_q
);

    localparam int WAIT_CYC = CLK_MHZ * WAIT_US;
    localparam int TW       = $clog2(WAIT_CYC + 1);
    localparam int SHIFT_W  = $clog2(SYS_W);
    localparam int COL_BASE = 9;
    localparam int ROW_BASE = 11;
    localparam int SH_MIN   = COL_BASE + 1;
    localparam int SH_MAX   = COL_BASE + (2**COL_W - 1) + ROW_BASE + (2**ROW_W - 1) + 2;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);
    localparam logic [ADDR_W-1:0] DLL_RST_MASK = ADDR_W'(1) << DLL_RST_BIT;
    localparam logic [ADDR_W-1:0] OCD_MASK     = ADDR_W'(7) << OCD_LSB;

    typedef struct packed {
        init_phase_e       phase;
        logic [STEP_W-1:0] step;
        ddr_cmd_e          cmd;
        logic [BA_W-1:0]   ba;
        logic [ADDR_W-1:0] addr;
        logic [SYS_W-1:0]  sys_addr;
        logic              done;
        logic [REFI_W-1:0] refi;
    } seq_state_t;

    seq_state_t s_d, s_q;

    logic [SHIFT_W-1:0] shift;
    logic               tmr_expired;
    logic               tmr_load;
    logic [TW-1:0]      tmr_val;

    // decode of the step that would issue next
    logic [STEP_W-1:0] nx_step;
    step_kind_e        nx_kind;
    ddr_cmd_e          nx_cmd;
    logic [BA_W-1:0]   nx_ba;
    logic [ADDR_W-1:0] nx_addr;
    logic [TW-1:0]     nx_gap;

    ddr2_bank_shift #(
        .COL_W   (COL_W),
        .ROW_W   (ROW_W),
        .SHIFT_W (SHIFT_W),
        .COL_BASE(COL_BASE),
        .ROW_BASE(ROW_BASE)
    ) u_shift (
        .col_i  (cfg_col),
        .row_i  (cfg_row),
        .seq_i  (cfg_seq_map),
        .wide_i (cfg_wide),
        .shift_o(shift)
    );

    ddr2_init_timer #(
        .TW     (TW),
        .RST_VAL(WAIT_CYC - 1)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .load_val_i(tmr_val),
        .expired_o (tmr_expired)
    );

    always_comb begin
        nx_step = (s_q.phase == PH_WAIT) ? '0 : s_q.step + STEP_W'(1);
        nx_kind = step_kind(nx_step);
        nx_cmd  = CMD_MRS;
        nx_ba   = '0;
        nx_addr = '0;
        nx_gap  = TW'(T_MRD - 1);
        case (nx_kind)
            K_PREA: begin
                nx_cmd  = CMD_PRE;
                nx_addr = ADDR_W'(1) << AP_BIT;
                nx_gap  = TW'(T_RP - 1);
            end
            K_REF: begin
                nx_cmd  = CMD_REF;
                nx_gap  = TW'(T_RFC - 1);
            end
            K_EMR2:         nx_ba = BA_W'(2);
            K_EMR3:         nx_ba = BA_W'(3);
            K_EMR1_DLL: begin
                nx_ba   = BA_W'(1);
                nx_addr = EMR1_BASE & ~OCD_MASK;
            end
            K_MR_DLLRST:    nx_addr = MR_BASE | DLL_RST_MASK;
            K_MR_RUN:       nx_addr = MR_BASE & ~DLL_RST_MASK;
            K_EMR1_OCDCAL: begin
                nx_ba   = BA_W'(1);
                nx_addr = EMR1_BASE | OCD_MASK;
            end
            default: begin
                nx_ba   = BA_W'(1);
                nx_addr = EMR1_BASE & ~OCD_MASK;
            end
        endcase
    end

    always_comb begin
        s_d          = s_q;
        s_d.cmd      = CMD_NOP;
        s_d.ba       = '0;
        s_d.addr     = '0;
        s_d.sys_addr = '0;
        tmr_load     = 1'b0;
        tmr_val      = nx_gap;
        case (s_q.phase)
            PH_WAIT, PH_RUN: begin
                if (tmr_expired) begin
                    if (s_q.phase == PH_RUN && s_q.step == LAST_STEP) begin
                        s_d.phase = PH_DONE;
                        s_d.done  = 1'b1;
                        s_d.refi  = cfg_refi;
                    end else begin
                        s_d.phase    = PH_RUN;
                        s_d.step     = nx_step;
                        s_d.cmd      = nx_cmd;
                        s_d.ba       = nx_ba;
                        s_d.addr     = nx_addr;
                        s_d.sys_addr = SYS_W'(nx_ba) << shift;
                        tmr_load     = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase    <= PH_WAIT;
            s_q.step     <= '0;
            s_q.cmd      <= CMD_NOP;
            s_q.ba       <= '0;
            s_q.addr     <= '0;
            s_q.sys_addr <= '0;
            s_q.done     <= 1'b0;
            s_q.refi     <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign {cs_n, ras_n, cas_n, we_n} = s_q.cmd;
    assign ba        = s_q.ba;
    assign addr      = s_q.addr;
    assign sys_addr  = s_q.sys_addr;
    assign init_done = s_q.done;
    assign refi_q    = s_q.refi;

    // R2
    wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_WAIT) |-> ({cs_n, ras_n, cas_n, we_n} == 4'b0111));

    // R10
    nop_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({cs_n, ras_n, cas_n, we_n} != 4'b0111) |=> ({cs_n, ras_n, cas_n, we_n} == 4'b0111));

    // R10
    idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> ({cs_n, ras_n, cas_n, we_n} == 4'b0111 && ba == '0));

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R7
    bank_only_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ba != '0) |-> ({cs_n, ras_n, cas_n, we_n} == 4'b0000));

    // R8
    sys_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ba == '0) |-> (sys_addr == '0));

    // R8
    shift_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift >= SHIFT_W'(SH_MIN)) && (shift <= SHIFT_W'(SH_MAX)));

endmodule

// File: tb/ddr2_pwrup_seq_bench.sv
module ddr2_pwrup_seq_bench;

    localparam int CLK_MHZ = 125;
    localparam int WAIT_US = 1;
    localparam int W       = CLK_MHZ * WAIT_US;
    localparam int G_MRD   = 2;
    localparam int G_RP    = 3;
    localparam int G_RFC   = 8;
    localparam logic [13:0] MRB  = 14'h0242;
    localparam logic [13:0] EM1B = 14'h0004;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_col = '0;
    logic [1:0]  cfg_row = '0;
    logic        cfg_seq_map = 1'b0;
    logic        cfg_wide = 1'b0;
    logic [11:0] cfg_refi = '0;
    logic        cs_n, ras_n, cas_n, we_n;
    logic [2:0]  ba;
    logic [13:0] addr;
    logic [31:0] sys_addr;
    logic        init_done;
    logic [11:0] refi_q;

    always #4 clk = ~clk;

    ddr2_pwrup_seq #(
        .CLK_MHZ  (CLK_MHZ),
        .WAIT_US  (WAIT_US),
        .T_MRD    (G_MRD),
        .T_RP     (G_RP),
        .T_RFC    (G_RFC),
        .MR_BASE  (MRB),
        .EMR1_BASE(EM1B)
    ) u_ddr2_pwrup_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_col    (cfg_col),
        .cfg_row    (cfg_row),
        .cfg_seq_map(cfg_seq_map),
        .cfg_wide   (cfg_wide),
        .cfg_refi   (cfg_refi),
        .cs_n       (cs_n),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n),
        .ba         (ba),
        .addr       (addr),
        .sys_addr   (sys_addr),
        .init_done  (init_done),
        .refi_q     (refi_q)
    );

    typedef struct {
        int          cyc;
        logic [3:0]  cmd;
        logic [2:0]  ba;
        logic [13:0] addr;
        string       tag;
    } exp_cmd_t;

    exp_cmd_t exp_q[$];
    int n_tests = 0;
    int n_fail  = 0;
    int t_now;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, expv, $time);
        end
    endtask

    task automatic push(input logic [3:0] c, input logic [2:0] b, input logic [13:0] a,
                        input int gap, input string tag);
        exp_cmd_t e;
        e.cyc = t_now; e.cmd = c; e.ba = b; e.addr = a; e.tag = tag;
        exp_q.push_back(e);
        t_now += gap;
    endtask

    task automatic run_cfg(input logic [1:0] col, input logic [1:0] row, input bit seq,
                           input bit wide, input logic [11:0] refi);
        int shamt;
        int done_cyc;
        @(negedge clk);
        rst_n = 1'b0;
        cfg_col = col; cfg_row = row; cfg_seq_map = seq; cfg_wide = wide; cfg_refi = refi;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1", "cmd", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
        chk(ba == 0 && addr == 0 && sys_addr == 0, "R1", "bus", {ba, addr}, 0);
        chk(init_done == 1'b0, "R1", "done", init_done, 0);
        chk(refi_q == 0, "R1", "refi", refi_q, 0);

        shamt = int'(col) + 9 + (seq ? int'(row) + 11 : 0) + (wide ? 2 : 1);
        exp_q.delete();
        t_now = W;
        push(4'b0010, 3'd0, 14'h0400, G_RP, "R5");
        push(4'b0000, 3'd2, 14'h0000, G_MRD, "R7");
        push(4'b0000, 3'd3, 14'h0000, G_MRD, "R7");
        push(4'b0000, 3'd1, EM1B, G_MRD, "R7");
        push(4'b0000, 3'd0, MRB | 14'h0100, G_MRD, "R6");
        push(4'b0010, 3'd0, 14'h0400, G_RP, "R5");
        push(4'b0001, 3'd0, 14'h0000, G_RFC, "R3");
        push(4'b0001, 3'd0, 14'h0000, G_RFC, "R3");
        push(4'b0000, 3'd0, MRB & ~14'h0100, G_MRD, "R6");
        push(4'b0000, 3'd1, EM1B | 14'h0380, G_MRD, "R7");
        push(4'b0000, 3'd1, EM1B & ~14'h0380, G_MRD, "R7");
        done_cyc = t_now;

        rst_n = 1'b1;
        for (int n = 1; n <= done_cyc + 6; n++) begin
            logic [3:0]  e_cmd;
            logic [2:0]  e_ba;
            logic [13:0] e_addr;
            logic [31:0] e_sys;
            string       tg;
            bit          e_done;
            @(posedge clk);
            @(negedge clk);
            e_cmd = 4'b0111; e_ba = 0; e_addr = 0;
            tg = (n < W) ? "R2" : ((n >= done_cyc) ? "R10" : "R4");
            if (exp_q.size() > 0 && exp_q[0].cyc == n) begin
                exp_cmd_t e;
                e = exp_q.pop_front();
                e_cmd = e.cmd; e_ba = e.ba; e_addr = e.addr;
                tg = (n == W) ? "R2" : "R3";
                chk(ba == e_ba && addr == e_addr, e.tag, "ba/addr", {ba, addr}, {e_ba, e_addr});
            end else begin
                chk(ba == 0 && addr == 0, "R10", "idle ba/addr", {ba, addr}, 0);
            end
            chk({cs_n, ras_n, cas_n, we_n} == e_cmd, tg, "cmd", {cs_n, ras_n, cas_n, we_n}, e_cmd);
            e_sys = 32'(e_ba) << shamt;
            chk(sys_addr == e_sys, "R8", "sys_addr", sys_addr, e_sys);
            e_done = (n >= done_cyc);
            chk(init_done == e_done, "R9", "init_done", init_done, e_done);
            chk(refi_q == (e_done ? refi : 12'd0), "R9", "refi_q", refi_q, e_done ? refi : 12'd0);
        end
    endtask

    initial begin
        run_cfg(2'd0, 2'd0, 1'b0, 1'b0, 12'h30c);
        run_cfg(2'd1, 2'd2, 1'b0, 1'b1, 12'h123);
        run_cfg(2'd2, 2'd1, 1'b1, 1'b0, 12'h5a5);
        run_cfg(2'd3, 2'd3, 1'b1, 1'b1, 12'hfff);
        run_cfg(2'd1, 2'd0, 1'b1, 1'b1, 12'h001);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog run did not finish actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule